// File: doc/BRIEF.md
# Multicast Port Flush Engine

This block walks an address table and strips a set of egress ports from every multicast address entry that matches a VLAN filter. A one-cycle start pulse captures a port mask, a 12-bit VLAN identifier and a flag that applies the flush to all VLANs. The engine then reads each table entry in turn through a synchronous memory port and decides whether to rewrite it. Unicast, broadcast and non-address entries are left alone.

When an entry's remaining port set becomes empty, the entry is released by marking its type as free. Otherwise only its port field is rewritten. The walk takes exactly two cycles per entry. Completion is flagged with a single-cycle done pulse.

Top module: `mcast_flush`

## Requirements
- R1: Out of reset, busy, done, the memory read enable and the memory write enable are all low.
- R2: A start pulse while idle captures flush mask, VLAN ID and all-VLANs flag; busy is high from the next cycle until the cycle that done is high. Done lasts one cycle, busy is low in that cycle, and a start pulse seen while busy is ignored.
- R3: Entries are read once each, in order from index 0 to DEPTH-1, with read data valid one cycle after the read enable. Each entry gets at most one write, issued in the cycle after its read and to the same index. Done rises 2*DEPTH cycles after the start edge.
- R4: Only entries whose type field (bits 61:60) is 1 (address) or 3 (address with VLAN) can be changed; type 0 and type 2 entries are never written.
- R5: Unless the all-VLANs flag is set, an entry can change only if its VLAN field (bits 59:48) equals the captured VLAN ID.
- R6: An entry can change only if bit 40 (the multicast bit) is set, and never when its 48-bit address field (bits 47:0) is all ones.
- R7: A qualifying entry whose port field (MASK_W bits starting at bit 66) shares no bit with the flush mask is not written.
- R8: Otherwise the flushed ports are cleared from the port field and, when ports remain, the entry is written back with every other bit unchanged.
- R9: When no ports remain, the entry is written with a zero port field and type 0 (free), all other bits unchanged.
- R10: A flush mask of zero walks the whole table and writes no entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to begin a walk |
| flushMask | input | MASK_W | Ports to remove |
| vlanId | input | 12 | VLAN to match |
| allVlans | input | 1 | Match every VLAN, ignore vlanId |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| memAddr | output | IDX_W | Table index for read or write |
| memRdEn | output | 1 | Table read request |
| memRdData | input | ENTRY_W | Entry returned one cycle after the read |
| memWrEn | output | 1 | Table write request |
| memWrData | output | ENTRY_W | Entry to write |

## Verification
A wrong walk state shows up at once on the memory port, as an out-of-order read index, a second write to one entry, or a write address that differs from the last read. It also shifts the done pulse away from cycle 2*DEPTH. A wrong filter or a wrong captured argument leaves the table contents different from the arithmetic expectation. This is visible when the table is inspected after done, and the number of writes counted on the port differs in the same walk. Near-exhaustive tables crossing every type, port mask and flush mask, with mixed VLANs and broadcast rows, expose each filter term separately.

// File: rtl/mflush_pkg.sv
package mflush_pkg;
  localparam int TYPE_LO   = 60;
  localparam int VLAN_LO   = 48;
  localparam int VLAN_W    = 12;
  localparam int MCAST_BIT = 40;
  localparam int ADDR_W    = 48;
  localparam int MASK_LO   = 66;

  localparam logic [1:0] TYPE_FREE  = 2'd0;
  localparam logic [1:0] TYPE_ADDR  = 2'd1;
  localparam logic [1:0] TYPE_VADDR = 2'd3;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_READ,
    ST_EVAL,
    ST_FIN
  } walkState_t;

  typedef struct packed {
    logic capture;
    logic evaluate;
  } flushStrobe_t;
endpackage

// File: rtl/mflush_ctrl.sv
module mflush_ctrl
  import mflush_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             needWrite,
  output flushStrobe_t     strobe,
  output logic [IDX_W-1:0] memAddr,
  output logic             memRdEn,
  output logic             memWrEn,
  output logic             busy,
  output logic             done
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

  walkState_t       state;
  logic [IDX_W-1:0] idx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      idx   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (start) begin
          state <= ST_READ;
          idx   <= '0;
        end
        ST_READ: state <= ST_EVAL;
        ST_EVAL: begin
          if (idx == LAST_IDX) begin
            state <= ST_FIN;
          end else begin
            idx   <= idx + 1'b1;
            state <= ST_READ;
          end
        end
        ST_FIN:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.capture  = (state == ST_IDLE) && start;
    strobe.evaluate = (state == ST_EVAL);
    memAddr = idx;
    memRdEn = (state == ST_READ);
    memWrEn = (state == ST_EVAL) && needWrite;
    busy    = (state == ST_READ) || (state == ST_EVAL);
    done    = (state == ST_FIN);
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R2
  AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(busy && done)); // R2
  AST_WR_FOLLOWS_RD: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |-> ($past(memRdEn) && memAddr == $past(memAddr))); // R3
  AST_NO_RD_WR_OVERLAP: assert property (@(posedge clk) disable iff (!rstN)
    !(memRdEn && memWrEn)); // R3
endmodule

// File: rtl/mflush_dp.sv
module mflush_dp
  import mflush_pkg::*;
#(
  parameter int MASK_W  = 3,
  parameter int ENTRY_W = 72
) (
  input  logic               clk,
  input  logic               rstN,
  input  flushStrobe_t       strobe,
  input  logic [MASK_W-1:0]  flushMask,
  input  logic [VLAN_W-1:0]  vlanId,
  input  logic               allVlans,
  input  logic [ENTRY_W-1:0] rdEntry,
  output logic               needWrite,
  output logic [ENTRY_W-1:0] wrEntry
);
  logic [MASK_W-1:0] flushQ;
  logic [VLAN_W-1:0] vlanQ;
  logic              allQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flushQ <= '0;
      vlanQ  <= '0;
      allQ   <= 1'b0;
    end else if (strobe.capture) begin
      flushQ <= flushMask;
      vlanQ  <= vlanId;
      allQ   <= allVlans;
    end
  end

  logic [1:0]        entType;
  logic [MASK_W-1:0] entMask;
  logic [MASK_W-1:0] leftMask;
  logic              isAddrType;
  logic              vlanOk;
  logic              isGroup;
  logic              overlap;

  always_comb begin
    entType    = rdEntry[TYPE_LO +: 2];
    entMask    = rdEntry[MASK_LO +: MASK_W];
    leftMask   = entMask & ~flushQ;
    isAddrType = (entType == TYPE_ADDR) || (entType == TYPE_VADDR);
    vlanOk     = allQ || (rdEntry[VLAN_LO +: VLAN_W] == vlanQ);
    isGroup    = rdEntry[MCAST_BIT] && (rdEntry[ADDR_W-1:0] != {ADDR_W{1'b1}});
    overlap    = |(entMask & flushQ);
    needWrite  = strobe.evaluate && isAddrType && vlanOk && isGroup && overlap;

    wrEntry = rdEntry;
    wrEntry[MASK_LO +: MASK_W] = leftMask;
    if (leftMask == '0) begin
      wrEntry[TYPE_LO +: 2] = TYPE_FREE;
    end
  end

  AST_KEEP_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    needWrite |-> (wrEntry[ADDR_W-1:0] == rdEntry[ADDR_W-1:0]
                   && rdEntry[ADDR_W-1:0] != {ADDR_W{1'b1}})); // R6
  AST_FREE_IFF_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    needWrite |-> ((wrEntry[MASK_LO +: MASK_W] == '0)
                   == (wrEntry[TYPE_LO +: 2] == TYPE_FREE))); // R9
  AST_ZERO_FLUSH_NO_WR: assert property (@(posedge clk) disable iff (!rstN)
    (flushQ == '0) |-> !needWrite); // R10
endmodule

// File: rtl/mcast_flush.sv
module mcast_flush
  import mflush_pkg::*;
#(
  parameter int DEPTH   = 64,
  parameter int MASK_W  = 3,
  parameter int ENTRY_W = 72,
  localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [MASK_W-1:0]  flushMask,
  input  logic [11:0]        vlanId,
  input  logic               allVlans,
  output logic               busy,
  output logic               done,
  output logic [IDX_W-1:0]   memAddr,
  output logic               memRdEn,
  input  logic [ENTRY_W-1:0] memRdData,
  output logic               memWrEn,
  output logic [ENTRY_W-1:0] memWrData
);
  flushStrobe_t strobe;
  logic         needWrite;

  mflush_ctrl #(.DEPTH(DEPTH)) i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .needWrite (needWrite),
    .strobe    (strobe),
    .memAddr   (memAddr),
    .memRdEn   (memRdEn),
    .memWrEn   (memWrEn),
    .busy      (busy),
    .done      (done)
  );

  mflush_dp #(.MASK_W(MASK_W), .ENTRY_W(ENTRY_W)) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .flushMask (flushMask),
    .vlanId    (vlanId),
    .allVlans  (allVlans),
    .rdEntry   (memRdData),
    .needWrite (needWrite),
    .wrEntry   (memWrData)
  );

  AST_WR_TYPE_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |-> (memWrData[TYPE_LO +: 2] != 2'd2)); // R4
endmodule

// File: tb/test_mcast_flush.sv
module test_mcast_flush;
  localparam int DEPTH = 32;
  localparam int MASK_W = 3;
  localparam int ENTRY_W = 72;
  localparam int IDX_W = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic allVlans = 1'b0;
  logic [MASK_W-1:0] flushMask = '0;
  logic [11:0] vlanId = '0;
  logic busy, done, memRdEn, memWrEn;
  logic [IDX_W-1:0] memAddr;
  logic [ENTRY_W-1:0] memRdData, memWrData;

  always #2 clk = ~clk;

  mcast_flush #(.DEPTH(DEPTH), .MASK_W(MASK_W), .ENTRY_W(ENTRY_W)) i_mcast_flush (
    .clk(clk), .rstN(rstN), .start(start), .flushMask(flushMask),
    .vlanId(vlanId), .allVlans(allVlans), .busy(busy), .done(done),
    .memAddr(memAddr), .memRdEn(memRdEn), .memRdData(memRdData),
    .memWrEn(memWrEn), .memWrData(memWrData)
  );

  logic [ENTRY_W-1:0] mem [DEPTH];
  logic loadEn = 1'b0;
  logic [IDX_W-1:0] loadAddr = '0;
  logic [ENTRY_W-1:0] loadData = '0;
  logic clrMon = 1'b0;

  always @(posedge clk) begin
    if (loadEn) mem[loadAddr] <= loadData;
    else if (memWrEn) mem[memAddr] <= memWrData;
    if (memRdEn) memRdData <= mem[memAddr];
  end

  int rdCount, wrCount, orderErr, dupWr;
  int lastRd;
  logic [DEPTH-1:0] wrote;
  always @(posedge clk) begin
    if (clrMon) begin
      rdCount = 0; wrCount = 0; orderErr = 0; dupWr = 0; lastRd = -1; wrote = '0;
    end else begin
      if (memRdEn) begin
        if (int'(memAddr) != rdCount) orderErr++;
        rdCount++;
        lastRd = int'(memAddr);
      end
      if (memWrEn) begin
        if (wrote[memAddr] || int'(memAddr) != lastRd) dupWr++;
        wrote[memAddr] = 1'b1;
        wrCount++;
      end
    end
  end

  int nChecks = 0;
  int nFail = 0;

  task automatic check(input bit ok, input string req, input logic [ENTRY_W-1:0] act,
                       input logic [ENTRY_W-1:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [ENTRY_W-1:0] mkEntry(input int i, input int r);
    logic [ENTRY_W-1:0] e = '0;
    int m = ((i / 4) + r) % 8;
    e[71:69] = 3'b101;
    e[68:66] = m[2:0];
    e[65:62] = i[3:0];
    e[61:60] = i[1:0];
    e[59:48] = (((i + r) % 3) == 0) ? 12'd5 : 12'd9;
    if (((i + r) % 7) == 3) begin
      e[47:0] = '1;
    end else begin
      e[47:0] = 48'h00_1234_0000 | 48'(i);
      e[40] = (((i + r) % 5) != 0);
    end
    return e;
  endfunction

  // expected entry from the requirements; tag names the deciding rule
  function automatic logic [ENTRY_W-1:0] expEntry(input logic [ENTRY_W-1:0] e,
      input logic [2:0] f, input logic [11:0] vid, input bit all, output string tag);
    logic [ENTRY_W-1:0] x = e;
    logic [2:0] rem = e[68:66] & ~f;
    if (f == 3'd0) tag = "R10";
    else if (!(e[61:60] == 2'd1 || e[61:60] == 2'd3)) tag = "R4";
    else if (!all && e[59:48] != vid) tag = "R5";
    else if (!e[40] || e[47:0] == '1) tag = "R6";
    else if ((e[68:66] & f) == 3'd0) tag = "R7";
    else if (rem != 3'd0) begin tag = "R8"; x[68:66] = rem; end
    else begin tag = "R9"; x[68:66] = 3'd0; x[61:60] = 2'd0; end
    return x;
  endfunction

  task automatic runFlush(input int r, input logic [2:0] f, input logic [11:0] vid,
                          input bit all, input bit disturb);
    logic [ENTRY_W-1:0] orig [DEPTH];
    int expWr = 0;
    int n = 0;
    bit hung = 0;
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge clk);
      orig[i] = mkEntry(i, r);
      loadEn = 1'b1; loadAddr = IDX_W'(i); loadData = orig[i];
    end
    @(negedge clk);
    loadEn = 1'b0; clrMon = 1'b1;
    @(negedge clk);
    clrMon = 1'b0;
    start = 1'b1; flushMask = f; vlanId = vid; allVlans = all;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    flushMask = ~f; vlanId = ~vid; allVlans = ~all;
    check(busy == 1'b1, "R2 busy after start", ENTRY_W'(busy), 1);
    while (!done) begin
      if (disturb && n == 10) start = 1'b1;
      else start = 1'b0;
      @(posedge clk); n++;
      @(negedge clk);
      if (n > 1000) begin hung = 1; break; end
    end
    start = 1'b0;
    if (hung) check(1'b0, "R3 walk hung", ENTRY_W'(n), ENTRY_W'(2 * DEPTH));
    check(n == 2 * DEPTH, "R3 done timing", ENTRY_W'(n), ENTRY_W'(2 * DEPTH));
    check(busy == 1'b0, "R2 busy low at done", ENTRY_W'(busy), 0);
    @(negedge clk);
    check(done == 1'b0, "R2 done one cycle", ENTRY_W'(done), 0);
    check(orderErr == 0 && rdCount == DEPTH, "R3 read order",
          ENTRY_W'(rdCount), ENTRY_W'(DEPTH));
    check(dupWr == 0, "R3 single write per entry", ENTRY_W'(dupWr), 0);
    for (int i = 0; i < DEPTH; i++) begin
      string tag;
      logic [ENTRY_W-1:0] ex = expEntry(orig[i], f, vid, all, tag);
      if (ex != orig[i]) expWr++;
      check(mem[i] === ex, $sformatf("%s entry %0d run %0d", tag, i, r), mem[i], ex);
    end
    check(wrCount == expWr, "R7 R10 write count", ENTRY_W'(wrCount), ENTRY_W'(expWr));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !done && !memRdEn && !memWrEn, "R1 reset outputs",
          ENTRY_W'({busy, done, memRdEn, memWrEn}), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!busy && !done && !memRdEn && !memWrEn, "R1 idle after reset",
          ENTRY_W'({busy, done, memRdEn, memWrEn}), 0);
    for (int r = 0; r < 8; r++) begin
      runFlush(r, 3'(r), (r < 4) ? 12'd5 : 12'd9, r[0], r == 3);
    end
    runFlush(5, 3'd7, 12'd9, 1'b0, 1'b0);
    runFlush(2, 3'd0, 12'd5, 1'b1, 1'b1);
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule